// File: doc/BRIEF.md
# Receive Ring Buffer Pointer Manager

This block keeps the pointers of a circular receive buffer held in local SRAM, which a packet writer and a DMA reader share. Incoming bytes arrive on a valid/ready port. Each accepted byte goes out on the SRAM write port at the current write pointer, and the pointer then advances. The consumer owns a boundary register. The writer never overtakes the consumer's read position, and one slot always stays empty so that a full ring can be told apart from an empty one.

The ring occupies a fixed address window, 0x4600 to 0x5FFF (6656 bytes). Both the write pointer and the DMA read address step from the top of the window back to its base. The DMA reader takes a start address and a byte count, then issues one read address per cycle. A parameter selects how the boundary register is read. It either holds the consumer's read pointer directly, or it holds that pointer minus one. In the second case a value written below the window base wraps to the top of the window.

Top module: `ring_rx_buf`

## Requirements
- R1: After reset, curr_ptr is 0x4600, free_cnt is 6655, wr_ready is 1, overflow is 0 and rd_en is 0.
- R2: In a cycle where wr_valid and wr_ready are both high, mem_we is high in that same cycle, with mem_waddr equal to curr_ptr and mem_wdata equal to wr_data. curr_ptr advances by one at the next clock edge. When no byte is accepted, mem_we is low and curr_ptr holds.
- R3: An accepted byte at address 0x5FFF moves curr_ptr to 0x4600.
- R4: The read pointer is rp. free_cnt equals (rp - curr_ptr - 1) modulo 6656, so it is 6655 when rp equals curr_ptr. wr_ready is high exactly when free_cnt is non-zero.
- R5: With BNRY_MINUS_ONE = 0, a value written through bnry_we/bnry_in becomes rp directly.
- R6: With BNRY_MINUS_ONE = 1, rp is the stored boundary plus one, and 0x5FFF is followed by 0x4600. A written value below 0x4600 is stored as that value plus 6656, so writing 0x45FF yields rp = 0x4600.
- R7: overflow is set at the clock edge after any cycle in which wr_valid is high and wr_ready is low. It then stays set until a cycle with bnry_we high and no new refused byte, which clears it.
- R8: A dma_start pulse with dma_len = N > 0, issued while rd_en is low, gives N consecutive cycles of rd_en starting on the next cycle. rd_addr begins at dma_addr and steps by one each cycle.
- R9: A DMA read address of 0x5FFF is followed by 0x4600.
- R10: A dma_start is ignored while rd_en is high, and a dma_start with dma_len = 0 issues no reads.
- R11: A boundary write changes free_cnt and wr_ready from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Incoming byte offered |
| wr_data | input | 8 | Incoming byte |
| wr_ready | output | 1 | Ring has room for the offered byte |
| bnry_we | input | 1 | Boundary register write strobe |
| bnry_in | input | 16 | New boundary value |
| dma_start | input | 1 | Start a DMA read burst |
| dma_addr | input | 16 | First address of the burst |
| dma_len | input | 16 | Number of bytes to read |
| mem_we | output | 1 | SRAM write strobe |
| mem_waddr | output | 16 | SRAM write address |
| mem_wdata | output | 8 | SRAM write data |
| rd_en | output | 1 | DMA read address valid |
| rd_addr | output | 16 | DMA read address |
| curr_ptr | output | 16 | Current write pointer |
| free_cnt | output | 16 | Bytes that can still be written |
| overflow | output | 1 | Sticky refused-byte flag |

## Verification
The assertions assume that every boundary value and every DMA start address lies inside the ring window. In the minus-one convention the value one below the base is also allowed. Burst lengths are taken as small relative to the window. The random stimulus draws boundary values only from the window, some of them close ahead of the write pointer so that the ring fills often. The minus-one instance gets the same boundary minus one, which puts 0x45FF on its input whenever the base is chosen. DMA starts use addresses in the window, biased toward the top, with lengths below 12, zero included.

// File: rtl/ring_rx_pkg.sv
package ring_rx_pkg;
  typedef enum logic {RD_IDLE = 1'b0, RD_RUN = 1'b1} rd_state_e;
endpackage

// File: rtl/ring_wr_ctrl.sv
module ring_wr_ctrl #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REGION_LO = 16'h4600,
  parameter logic [ADDR_W-1:0] REGION_HI = 16'h5FFF,
  parameter bit BNRY_MINUS_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              bnry_we,
  input  logic [ADDR_W-1:0] bnry_in,
  output logic              wr_ready,
  output logic              accept,
  output logic [ADDR_W-1:0] curr_ptr,
  output logic [ADDR_W-1:0] free_cnt,
  output logic              overflow
);
  localparam logic [ADDR_W:0] SPAN = {1'b0, REGION_HI} - {1'b0, REGION_LO} + (ADDR_W+1)'(1);
  localparam logic [ADDR_W-1:0] BNRY_RST = BNRY_MINUS_ONE ? REGION_HI : REGION_LO;

  logic [ADDR_W-1:0] curr_q, curr_d, bnry_q, bnry_d, rdptr, bnry_norm;
  logic [ADDR_W:0]   free_w, rp_w, cp_w, lift_w;
  logic              ovf_q, ovf_d;

  // boundary normalisation and read pointer derivation per convention
  generate
    if (BNRY_MINUS_ONE) begin : g_minus_one
      always_comb begin
        lift_w    = {1'b0, bnry_in} + SPAN;
        bnry_norm = (bnry_in < REGION_LO) ? lift_w[ADDR_W-1:0] : bnry_in;
        rdptr     = (bnry_q == REGION_HI) ? REGION_LO : bnry_q + ADDR_W'(1);
      end
    end else begin : g_equal
      always_comb begin
        lift_w    = '0;
        bnry_norm = bnry_in;
        rdptr     = bnry_q;
      end
    end
  endgenerate

  always_comb begin
    rp_w = {1'b0, rdptr};
    cp_w = {1'b0, curr_q};
    if (rp_w > cp_w) free_w = rp_w - cp_w - (ADDR_W+1)'(1);
    else             free_w = rp_w + SPAN - cp_w - (ADDR_W+1)'(1);
  end

  assign free_cnt = free_w[ADDR_W-1:0];
  assign wr_ready = (free_cnt != '0);
  assign accept   = wr_valid & wr_ready;

  always_comb begin
    curr_d = (curr_q == REGION_HI) ? REGION_LO : curr_q + ADDR_W'(1);
    bnry_d = bnry_norm;
    ovf_d  = (wr_valid & ~wr_ready) | (ovf_q & ~bnry_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curr_q <= REGION_LO;
      bnry_q <= BNRY_RST;
      ovf_q  <= 1'b0;
    end else begin
      if (accept)  curr_q <= curr_d;
      if (bnry_we) bnry_q <= bnry_d;
      ovf_q <= ovf_d;
    end
  end

  assign curr_ptr = curr_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/ring_dma_rd.sv
module ring_dma_rd
  import ring_rx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter logic [ADDR_W-1:0] REGION_LO = 16'h4600,
  parameter logic [ADDR_W-1:0] REGION_HI = 16'h5FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_start,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [LEN_W-1:0]  dma_len,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  rd_state_e         st_q, st_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              upd;

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    rem_d = rem_q;
    upd   = 1'b0;
    case (st_q)
      RD_IDLE: begin
        if (dma_start && (dma_len != '0)) begin
          st_d  = RD_RUN;
          ptr_d = dma_addr;
          rem_d = dma_len;
          upd   = 1'b1;
        end
      end
      RD_RUN: begin
        upd   = 1'b1;
        ptr_d = (ptr_q == REGION_HI) ? REGION_LO : ptr_q + ADDR_W'(1);
        rem_d = rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) st_d = RD_IDLE;
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RD_IDLE;
      ptr_q <= REGION_LO;
      rem_q <= '0;
    end else if (upd) begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      rem_q <= rem_d;
    end
  end

  assign rd_en   = (st_q == RD_RUN);
  assign rd_addr = ptr_q;
endmodule

// File: rtl/ring_rx_buf.sv
module ring_rx_buf #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REGION_LO = 16'h4600,
  parameter logic [ADDR_W-1:0] REGION_HI = 16'h5FFF,
  parameter bit BNRY_MINUS_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              bnry_we,
  input  logic [ADDR_W-1:0] bnry_in,
  input  logic              dma_start,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [LEN_W-1:0]  dma_len,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] curr_ptr,
  output logic [ADDR_W-1:0] free_cnt,
  output logic              overflow
);
  logic accept;

  ring_wr_ctrl #(
    .ADDR_W(ADDR_W), .REGION_LO(REGION_LO), .REGION_HI(REGION_HI),
    .BNRY_MINUS_ONE(BNRY_MINUS_ONE)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .bnry_we(bnry_we),
    .bnry_in(bnry_in), .wr_ready(wr_ready), .accept(accept),
    .curr_ptr(curr_ptr), .free_cnt(free_cnt), .overflow(overflow)
  );

  ring_dma_rd #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .REGION_LO(REGION_LO), .REGION_HI(REGION_HI)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .dma_start(dma_start), .dma_addr(dma_addr),
    .dma_len(dma_len), .rd_en(rd_en), .rd_addr(rd_addr)
  );

  assign mem_we    = accept;
  assign mem_waddr = curr_ptr;
  assign mem_wdata = wr_data;
endmodule

// File: rtl/ring_rx_buf_chk.sv
module ring_rx_buf_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REGION_LO = 16'h4600,
  parameter logic [ADDR_W-1:0] REGION_HI = 16'h5FFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              bnry_we,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] curr_ptr,
  input logic [ADDR_W-1:0] free_cnt,
  input logic              overflow
);
  a_r2_write_at_curr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_waddr == curr_ptr) && wr_valid && wr_ready);

  a_r3_curr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> curr_ptr == (($past(mem_waddr) == REGION_HI) ? REGION_LO
                                                             : $past(mem_waddr) + ADDR_W'(1)));

  a_r2_curr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |=> $stable(curr_ptr));

  a_r4_ready_free: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == (free_cnt != '0));

  a_r4_free_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !bnry_we) |=> free_cnt == $past(free_cnt) - ADDR_W'(1));

  a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> overflow);

  a_r7_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !bnry_we) |=> overflow);

  a_r8_rd_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr >= REGION_LO) && (rd_addr <= REGION_HI));

  a_r9_rd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == REGION_HI) |=> (!rd_en || rd_addr == REGION_LO));
endmodule

bind ring_rx_buf ring_rx_buf_chk #(
  .ADDR_W(ADDR_W), .REGION_LO(REGION_LO), .REGION_HI(REGION_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .bnry_we(bnry_we), .mem_we(mem_we), .mem_waddr(mem_waddr), .rd_en(rd_en),
  .rd_addr(rd_addr), .curr_ptr(curr_ptr), .free_cnt(free_cnt), .overflow(overflow)
);

// File: tb/tb_ring_rx_buf.sv
`timescale 1ns/1ps
module tb_ring_rx_buf;
  localparam int LO   = 16'h4600;
  localparam int HI   = 16'h5FFF;
  localparam int SPAN = HI - LO + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, bnry_we = 1'b0, dma_start = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [15:0] bnry_in = 16'(LO), bnry_in_m1, dma_addr = 16'(LO), dma_len = '0;
  logic        wr_ready, mem_we, rd_en, overflow;
  logic [15:0] mem_waddr, rd_addr, curr_ptr, free_cnt;
  logic [7:0]  mem_wdata;
  logic        wr_ready_m1, mem_we_m1, rd_en_m1, overflow_m1;
  logic [15:0] mem_waddr_m1, rd_addr_m1, curr_ptr_m1, free_cnt_m1;
  logic [7:0]  mem_wdata_m1;

  int checks = 0, errors = 0;
  int m_curr, m_rp, m_ptr, m_rem;
  bit m_ovf, m_busy;
  string ptag = "";

  assign bnry_in_m1 = bnry_in - 16'd1;

  always #4 clk = ~clk;

  ring_rx_buf dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .bnry_we(bnry_we), .bnry_in(bnry_in), .dma_start(dma_start), .dma_addr(dma_addr),
    .dma_len(dma_len), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .curr_ptr(curr_ptr), .free_cnt(free_cnt),
    .overflow(overflow));

  ring_rx_buf #(.BNRY_MINUS_ONE(1'b1)) dut_m1 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready_m1),
    .bnry_we(bnry_we), .bnry_in(bnry_in_m1), .dma_start(dma_start), .dma_addr(dma_addr),
    .dma_len(dma_len), .mem_we(mem_we_m1), .mem_waddr(mem_waddr_m1), .mem_wdata(mem_wdata_m1),
    .rd_en(rd_en_m1), .rd_addr(rd_addr_m1), .curr_ptr(curr_ptr_m1), .free_cnt(free_cnt_m1),
    .overflow(overflow_m1));

  function automatic int nxt(int a);
    return (a == HI) ? LO : a + 1;
  endfunction

  function automatic int freef(int rp, int c);
    if (rp > c) return rp - c - 1;
    return rp + SPAN - c - 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", ptag, tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check, then advance the model at posedge
  task automatic step(input bit v, input bit bw, input int bv, input bit ds,
                      input int da, input int dl);
    int  ef;
    bit  er, ewe;
    @(negedge clk);
    wr_valid = v; wr_data = 8'($urandom); bnry_we = bw; bnry_in = 16'(bv);
    dma_start = ds; dma_addr = 16'(da); dma_len = 16'(dl);
    #1;
    ef = freef(m_rp, m_curr); er = (ef != 0); ewe = v && er;
    chk("R4 R5 R11 free_cnt", int'(free_cnt), ef);
    chk("R4 wr_ready", int'(wr_ready), int'(er));
    chk("R2 R3 curr_ptr", int'(curr_ptr), m_curr);
    chk("R2 mem_we", int'(mem_we), int'(ewe));
    if (ewe) begin
      chk("R2 mem_waddr", int'(mem_waddr), m_curr);
      chk("R2 mem_wdata", int'(mem_wdata), int'(wr_data));
    end
    chk("R7 overflow", int'(overflow), int'(m_ovf));
    chk("R8 R10 rd_en", int'(rd_en), int'(m_busy));
    if (m_busy) chk("R8 R9 rd_addr", int'(rd_addr), m_ptr);
    chk("R6 free_cnt minus-one", int'(free_cnt_m1), ef);
    chk("R6 wr_ready minus-one", int'(wr_ready_m1), int'(er));
    chk("R6 curr_ptr minus-one", int'(curr_ptr_m1), m_curr);
    chk("R6 overflow minus-one", int'(overflow_m1), int'(m_ovf));
    @(posedge clk);
    if (ewe) m_curr = nxt(m_curr);
    m_ovf = (v && !er) || (m_ovf && !bw);
    if (bw) m_rp = bv;
    if (m_busy) begin
      m_ptr = nxt(m_ptr); m_rem--;
      if (m_rem == 0) m_busy = 0;
    end else if (ds && dl != 0) begin
      m_busy = 1; m_ptr = da; m_rem = dl;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bv;
    void'($urandom(32'd20240611));
    m_curr = LO; m_rp = LO; m_ovf = 0; m_busy = 0; m_ptr = LO; m_rem = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    ptag = "R1 reset";
    step(0, 0, LO, 0, LO, 0);
    chk("R1 free after reset", int'(free_cnt), SPAN - 1);

    ptag = "R9 R10 dma";
    step(0, 0, LO, 1, HI - 1, 4);
    step(0, 0, LO, 1, LO + 100, 9);   // ignored: busy
    for (int i = 0; i < 5; i++) step(0, 0, LO, 0, LO, 0);
    step(0, 0, LO, 1, LO, 0);         // zero length
    step(0, 0, LO, 0, LO, 0);

    ptag = "R4 R7 fill";
    step(0, 1, LO + 3, 0, LO, 0);
    for (int i = 0; i < 5; i++) step(1, 0, LO + 3, 0, LO, 0);
    step(0, 0, LO + 3, 0, LO, 0);
    step(0, 1, LO + 10, 0, LO, 0);
    step(0, 0, LO, 0, LO, 0);

    ptag = "R3 R6 wrap";
    step(0, 1, LO, 0, LO, 0);         // minus-one instance sees 0x45FF
    for (int i = 0; i < 7000; i++) step(1, 0, LO, 0, LO, 0);

    ptag = "random";
    for (int i = 0; i < 40000; i++) begin
      int r = int'($urandom % 100);
      if (r < 40)      bv = LO + int'($urandom % SPAN);
      else if (r < 60) bv = LO;
      else begin
        bv = m_curr + int'($urandom % 8);
        if (bv > HI) bv -= SPAN;
      end
      step(($urandom % 100) < 75, ($urandom % 100) < 3, bv,
           ($urandom % 100) < 6,
           (($urandom % 2) == 1) ? HI - int'($urandom % 4) : LO + int'($urandom % SPAN),
           int'($urandom % 12));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule